// File: doc/BRIEF.md
# Orderwire Demultiplexer with Activity Alarm

This block takes a redundantly coded orderwire stream together with its 2 kHz timing signal and recovers one orderwire bit per timing period. Every bit is sent as a group of two halves whose first half carries the bit value. The timing signal rises at the start of each group, so the block samples the coded stream only on the timing signal's rising edge and holds that value until the next rising edge. The voice data and voice timing signals pass through to the outputs, and so does the timing signal. All four inputs are asynchronous and are sampled on one fast system clock.

An activity supervisor watches all four inputs. A signal counts as alive while it has changed level within a timeout, which is set in system clock cycles through parameters and defaults to four timing periods. The voice pair and the orderwire pair each report good only while both of their signals are alive. One fail flag rises when either pair is not good, and a status lamp output follows it. A mode input selects digital or analog orderwire operation. In analog mode every data and timing output is held low and the fail flag is held off, while the activity timers keep running.

Top module: `ow_demux_supervisor`

## Requirements
- R1: Each of the four inputs passes through a two-flop synchronizer. In digital mode `voice_data_out` and `voice_clk_out` equal the level their inputs had before the third rising system clock edge back, which is a latency of three clock edges.
- R2: `ow_bit_out` takes the synchronized level of `ow_coded_in` only on a cycle where the synchronized `ow_tick_in` goes from 0 to 1, and it holds its value on every other cycle. A redundant group whose first half is 1 and second half is 0 decodes as 1, and a group of 0 then 1 decodes as 0.
- R3: In digital mode `ow_tick_out` follows `ow_tick_in` with the same three-edge latency as R1.
- R4: A monitored signal is alive while no more than TIMEOUT cycles have passed since a change in its synchronized level. TIMEOUT = (SYS_HZ / TICK_HZ) * TIMEOUT_PERIODS.
- R5: In digital mode `fail_flag` is 1 in the cycle after any of the four signals is not alive, and 0 in the cycle after all four are alive.
- R6: While `analog_mode` is 1 at a clock edge, all four data and timing outputs and `fail_flag` are 0 after that edge.
- R7: Reset clears every output and the held orderwire bit to 0 and puts all four monitors in the not-alive state, so `fail_flag` rises on the first digital-mode edge after reset.
- R8: The activity timers keep running in analog mode. On the first edge after a return to digital mode, `fail_flag` reflects the activity seen during the analog period.
- R9: `lamp_on` is always equal to `fail_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| analog_mode | input | 1 | 1 selects analog orderwire mode, 0 selects digital |
| voice_data_in | input | 1 | Asynchronous voice data |
| voice_clk_in | input | 1 | Asynchronous voice timing |
| ow_coded_in | input | 1 | Asynchronous redundantly coded orderwire stream |
| ow_tick_in | input | 1 | Asynchronous 2 kHz orderwire timing |
| voice_data_out | output | 1 | Synchronized voice data, gated by the mode |
| voice_clk_out | output | 1 | Synchronized voice timing, gated by the mode |
| ow_bit_out | output | 1 | Decoded orderwire bit, gated by the mode |
| ow_tick_out | output | 1 | Synchronized orderwire timing, gated by the mode |
| fail_flag | output | 1 | 1 when any monitored signal is inactive (digital mode only) |
| lamp_on | output | 1 | Status lamp drive, equal to the fail flag |

## Verification
The assertions assume that `analog_mode` is a synchronous, quasi-static input. They also assume the coded stream changes only at the timing signal's edges, so the rising-edge sample always falls on the first half of a redundant group. The stimulus drives every input on falling clock edges. It changes the coded stream in the same cycle as the timing signal, keeps the timing half-period at a fixed 16 cycles, and drives the mode only from the stimulus loop. Outages last well beyond TIMEOUT, so that each pair clearly fails and then recovers.

// File: rtl/ow_pkg.sv
package ow_pkg;
    localparam int unsigned NUM_MON = 4;
    typedef enum logic [1:0] {
        IDX_VDAT = 2'd0,
        IDX_VCLK = 2'd1,
        IDX_CODE = 2'd2,
        IDX_TICK = 2'd3
    } mon_idx_e;

    typedef struct packed {
        logic vdat;
        logic vclk;
        logic owbit;
        logic owtick;
        logic fail;
    } ow_out_t;
endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] prv
);
    logic [WIDTH-1:0] meta_q, meta_d;
    logic [WIDTH-1:0] lvl_q, lvl_d;
    logic [WIDTH-1:0] prv_q, prv_d;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            always_comb begin
                meta_d[gi] = async_in[gi];
                lvl_d[gi]  = meta_q[gi];
                prv_d[gi]  = lvl_q[gi];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_q[gi] <= 1'b0;
                    lvl_q[gi]  <= 1'b0;
                    prv_q[gi]  <= 1'b0;
                end else begin
                    meta_q[gi] <= meta_d[gi];
                    lvl_q[gi]  <= lvl_d[gi];
                    prv_q[gi]  <= prv_d[gi];
                end
            end
        end
    endgenerate

    assign lvl = lvl_q;
    assign prv = prv_q;
endmodule

// File: rtl/act_watch.sv
module act_watch #(
    parameter int unsigned TIMEOUT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic prv,
    output logic alive
);
    localparam int unsigned CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

    logic [CW-1:0] cnt_q, cnt_d;
    logic          toggle;

    always_comb begin
        toggle = lvl ^ prv;
        if (toggle)
            cnt_d = '0;
        else if (cnt_q != LIMIT)
            cnt_d = cnt_q + 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= LIMIT;
        else        cnt_q <= cnt_d;
    end

    assign alive = (cnt_q != LIMIT);

    // R4: a level change makes the signal alive from the next cycle
    assert_toggle_revives_R4: assert property (@(posedge clk) disable iff (!rst_n)
        toggle |=> alive);
    // R4: with no change, a dead signal stays dead
    assert_dead_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!alive && !toggle) |=> !alive);
endmodule

// File: rtl/ow_bit_capture.sv
module ow_bit_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_lvl,
    input  logic tick_prv,
    input  logic code_lvl,
    output logic hold_nxt,
    output logic hold
);
    logic hold_q, hold_d;
    logic rise;

    always_comb begin
        rise   = tick_lvl & ~tick_prv;
        hold_d = rise ? code_lvl : hold_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= hold_d;
    end

    assign hold_nxt = hold_d;
    assign hold     = hold_q;

    // R2: value changes only at a synchronized rising tick
    assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_lvl && !tick_prv) |=> $stable(hold_q));
    // R2: at a rising tick the coded level is taken
    assert_hold_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_lvl && !tick_prv) |=> (hold_q == $past(code_lvl)));
endmodule

// File: rtl/ow_demux_supervisor.sv
module ow_demux_supervisor
    import ow_pkg::*;
#(
    parameter int unsigned SYS_HZ          = 50000000,
    parameter int unsigned TICK_HZ         = 2000,
    parameter int unsigned TIMEOUT_PERIODS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic analog_mode,
    input  logic voice_data_in,
    input  logic voice_clk_in,
    input  logic ow_coded_in,
    input  logic ow_tick_in,
    output logic voice_data_out,
    output logic voice_clk_out,
    output logic ow_bit_out,
    output logic ow_tick_out,
    output logic fail_flag,
    output logic lamp_on
);
    localparam int unsigned TIMEOUT = (SYS_HZ / TICK_HZ) * TIMEOUT_PERIODS;

    logic [NUM_MON-1:0] raw_in, lvl, prv, alive;
    logic               hold_nxt, hold;
    logic               voice_good, ow_good;
    ow_out_t            out_q, out_d;

    assign raw_in[IDX_VDAT] = voice_data_in;
    assign raw_in[IDX_VCLK] = voice_clk_in;
    assign raw_in[IDX_CODE] = ow_coded_in;
    assign raw_in[IDX_TICK] = ow_tick_in;

    sync_bank #(.WIDTH(NUM_MON)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .lvl      (lvl),
        .prv      (prv)
    );

    genvar mi;
    generate
        for (mi = 0; mi < NUM_MON; mi++) begin : g_mon
            act_watch #(.TIMEOUT(TIMEOUT)) u_watch (
                .clk   (clk),
                .rst_n (rst_n),
                .lvl   (lvl[mi]),
                .prv   (prv[mi]),
                .alive (alive[mi])
            );
        end
    endgenerate

    ow_bit_capture u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_lvl (lvl[IDX_TICK]),
        .tick_prv (prv[IDX_TICK]),
        .code_lvl (lvl[IDX_CODE]),
        .hold_nxt (hold_nxt),
        .hold     (hold)
    );

    always_comb begin
        voice_good = alive[IDX_VDAT] & alive[IDX_VCLK];
        ow_good    = alive[IDX_CODE] & alive[IDX_TICK];
        out_d      = '0;
        if (!analog_mode) begin
            out_d.vdat   = lvl[IDX_VDAT];
            out_d.vclk   = lvl[IDX_VCLK];
            out_d.owbit  = hold_nxt;
            out_d.owtick = lvl[IDX_TICK];
            out_d.fail   = ~(voice_good & ow_good);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign voice_data_out = out_q.vdat;
    assign voice_clk_out  = out_q.vclk;
    assign ow_bit_out     = out_q.owbit;
    assign ow_tick_out    = out_q.owtick;
    assign fail_flag      = out_q.fail;
    assign lamp_on        = out_q.fail;

    // R6: analog mode mutes every output on the next edge
    assert_analog_mute_R6: assert property (@(posedge clk) disable iff (!rst_n)
        analog_mode |=> (!fail_flag && !voice_data_out && !voice_clk_out
                         && !ow_bit_out && !ow_tick_out));
    // R5: any dead monitor in digital mode raises the flag
    assert_fail_on_dead_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!analog_mode && (alive != '1)) |=> fail_flag);
    // R5: all monitors alive in digital mode clears the flag
    assert_clear_on_alive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!analog_mode && (alive == '1)) |=> !fail_flag);
    // R2: decoded output changes only after a rising tick or a mode step
    assert_bit_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!analog_mode && !(lvl[IDX_TICK] && !prv[IDX_TICK]) && !$past(analog_mode))
            |=> $stable(ow_bit_out));
    // R9: lamp mirrors the flag
    always_comb begin
        assert_lamp_mirror_R9: assert (lamp_on == fail_flag);
    end
endmodule

// File: tb/ow_demux_supervisor_test.sv
module ow_demux_supervisor_test;
    localparam int SYS_HZ = 64000;
    localparam int TICK_HZ = 2000;
    localparam int PERIODS = 4;
    localparam int TMO = (SYS_HZ / TICK_HZ) * PERIODS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic analog_mode = 1'b0;
    logic vdat = 1'b0, vclk = 1'b0, coded = 1'b0, tick = 1'b0;
    logic o_vdat, o_vclk, o_bit, o_tick, o_fail, o_lamp;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    ow_demux_supervisor #(
        .SYS_HZ(SYS_HZ), .TICK_HZ(TICK_HZ), .TIMEOUT_PERIODS(PERIODS)
    ) uut (
        .clk(clk), .rst_n(rst_n), .analog_mode(analog_mode),
        .voice_data_in(vdat), .voice_clk_in(vclk),
        .ow_coded_in(coded), .ow_tick_in(tick),
        .voice_data_out(o_vdat), .voice_clk_out(o_vclk),
        .ow_bit_out(o_bit), .ow_tick_out(o_tick),
        .fail_flag(o_fail), .lamp_on(o_lamp)
    );

    // behavioural reference: input history, idle timers, held bit
    logic [3:0] h1, h2, h3;
    int         idle [4];
    logic       m_hold, m_vdat, m_vclk, m_bit, m_tick, m_fail;

    always @(posedge clk) begin
        if (!rst_n) begin
            h1 = '0; h2 = '0; h3 = '0;
            foreach (idle[i]) idle[i] = TMO;
            m_hold = 0; m_vdat = 0; m_vclk = 0; m_bit = 0; m_tick = 0; m_fail = 0;
        end else begin
            bit all_ok;
            all_ok = 1;
            foreach (idle[i]) if (idle[i] >= TMO) all_ok = 0;
            foreach (idle[i]) begin
                if (h2[i] != h3[i]) idle[i] = 0;
                else if (idle[i] < TMO) idle[i] = idle[i] + 1;
            end
            if (h2[3] && !h3[3]) m_hold = h2[2];
            m_vdat = analog_mode ? 1'b0 : h2[0];
            m_vclk = analog_mode ? 1'b0 : h2[1];
            m_tick = analog_mode ? 1'b0 : h2[3];
            m_bit  = analog_mode ? 1'b0 : m_hold;
            m_fail = analog_mode ? 1'b0 : !all_ok;
            h3 = h2; h2 = h1; h1 = {tick, coded, vclk, vdat};
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at t=%0t", tag, act, exp, $time);
        end
    endtask

    logic [15:0] lfsr = 16'hACE1;
    function automatic logic [15:0] step(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    bit done = 0;
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic sent_bit;
        bit kill_vclk, kill_tick;
        sent_bit = 0;
        repeat (3) @(negedge clk);
        // R7: reset state
        check("R7 reset vdat", o_vdat, 1'b0);
        check("R7 reset bit", o_bit, 1'b0);
        check("R7 reset fail", o_fail, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 fail after reset", o_fail, 1'b1);
        for (int cyc = 0; cyc < 2100; cyc++) begin
            @(negedge clk);
            check("R1 voice data", o_vdat, m_vdat);
            check("R1 voice clk", o_vclk, m_vclk);
            check("R2 ow bit", o_bit, m_bit);
            check("R3 ow tick", o_tick, m_tick);
            check("R5 fail", o_fail, m_fail);
            check("R9 lamp", o_lamp, o_fail);
            if (cyc == 390) check("R5 healthy clear", o_fail, 1'b0);
            if (cyc == 690) check("R4 R5 voice clk dead", o_fail, 1'b1);
            if (cyc == 990) check("R5 recovered", o_fail, 1'b0);
            if (cyc == 1290) check("R4 R5 tick dead", o_fail, 1'b1);
            if (cyc == 1290) check("R2 bit held while tick dead", o_bit, sent_bit);
            if (cyc == 1500) check("R2 bit decoded", o_bit, sent_bit);
            if (cyc == 1700) check("R6 analog fail muted", o_fail, 1'b0);
            if (cyc == 1700) check("R6 analog tick muted", o_tick, 1'b0);
            if (cyc == 1801) check("R8 fail on return", o_fail, 1'b1);
            if (cyc == 2090) check("R8 cleared after recovery", o_fail, 1'b0);

            kill_vclk = (cyc >= 400 && cyc < 700) || (cyc >= 1600 && cyc < 1800);
            kill_tick = (cyc >= 1000 && cyc < 1300);
            analog_mode = (cyc >= 1550 && cyc < 1800);
            lfsr = step(lfsr);
            if (!kill_vclk && (cyc % 2 == 0)) begin
                vclk = ~vclk;
                if (vclk) vdat = lfsr[0];
            end
            if (!kill_tick && (cyc % 16 == 0)) begin
                tick = ~tick;
                if (tick) begin
                    sent_bit = lfsr[5];
                    coded = sent_bit;     // first half carries the value
                end else begin
                    coded = ~sent_bit;    // second half is redundant
                end
            end
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule